// File: doc/BRIEF.md
# SCSI Controller Host Register File

This block is the byte-wide register window that a host processor sees on a small SCSI protocol controller. The host selects one of sixteen offsets with a 4-bit address and reads or writes one byte at a time. The block holds a 24-bit start transfer count, a command byte, a destination ID, four control bytes, a main status byte and an interrupt status byte. It drives one active-high interrupt line.

The bus sequencer and the data path sit beside this block and are not part of it. When the host writes a command, the block emits a one-cycle strobe and holds the command byte for those neighbours. They report progress back through an event port, which ORs in interrupt causes, loads the main status condition flags and raises the interrupt. A separate port lets them set the bus phase. The live transfer counter is kept by the neighbour and comes in as an input, so that the host can read it.

Offset 14 has two uses. With the feature-enable bit set, a DMA-flavoured no-op command lets the host read a fixed identification byte there. Any write to that offset replaces the identification byte with the top byte of the live counter, and it also sets a lock that only reset clears.

Top module: `scsi_host_regs`

## Requirements
- R1: After reset, main status (offset 4) reads 0x03: interrupt clear, condition flags clear, phase field = STATUS (MSG=0, C/D=1, I/O=1). Interrupt status (offset 5), the control bytes (offsets 8, 11, 12, 13), offset 14, start_count and irq all read zero. The chip-ID visibility and lock flags are cleared.
- R2: A write to offset 0 loads start_count[7:0] and a write to offset 1 loads start_count[15:8]. A read of offset 0 returns xfer_count[7:0] and a read of offset 1 returns xfer_count[15:8].
- R3: Offsets 8, 11, 12 and 13 are read/write control bytes. Offset 3 reads back the last command byte. A write to offset 4 sets dest_id.
- R4: Main status layout: bit 7 interrupt, bit 6 illegal operation, bit 5 parity error, bit 4 count zero, bit 3 group valid, bits 2..0 phase (MSG, C/D, I/O). A cycle with evt_valid ORs evt_irq into interrupt status, loads evt_flags into bits 6..3 and sets bit 7, so irq is high from the next cycle. A cycle with phase_we loads phase_in into bits 2..0.
- R5: Interrupt status layout: bit 7 bus reset, bit 6 invalid command, bit 5 disconnected, bit 4 service request, bit 3 function complete, bit 2 reselected, bit 1 selected with attention, bit 0 selected. A read of offset 5 returns it unchanged, then clears main status bit 7 and drops irq.
- R6: A write to offset 3 clears main status bit 7 and zeroes interrupt status. In the next cycle cmd_stb is high for one cycle, with cmd_code equal to the byte written.
- R7: A command whose low seven bits are zero is a no-op. It completes at once: interrupt status becomes 0x08 and irq rises.
- R8: Offset 14 depends on control byte 11, bit 6. While that bit is clear, offset 14 reads 0x00 and writes to it change nothing.
- R9: Writing command 0x80 while the lock is clear makes offset 14 return CHIP_ID (default 0xA2) whenever control byte 11 bit 6 is set. Command 0x00 does not reveal the ID.
- R10: With control byte 11 bit 6 set, a write to offset 14 loads start_count[23:16], hides the ID and sets the lock. Offset 14 then reads xfer_count[23:16], and later 0x80 commands do not reveal the ID until the next reset.
- R11: Offsets 2, 6, 7, 9, 10 and 15 read 0x00. Host writes to offsets 2, 5, 6, 7, 9, 10 and 15 have no effect.
- R12: If an event arrives in the same cycle as a command write, the event's interrupt bits and interrupt flag are applied after the command's clear, so they remain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write enable |
| rd_en | input | 1 | Host read enable (drives read side effects) |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, combinational from addr |
| irq | output | 1 | Interrupt request, active high |
| xfer_count | input | 24 | Live transfer counter from the data path |
| evt_valid | input | 1 | Neighbour status event |
| evt_irq | input | 8 | Interrupt causes to OR in |
| evt_flags | input | 4 | Main status bits 6..3 to load |
| phase_we | input | 1 | Phase update strobe |
| phase_in | input | 3 | New phase (MSG, C/D, I/O) |
| start_count | output | 24 | Programmed start transfer count |
| dest_id | output | 8 | Destination ID byte |
| cmd_stb | output | 1 | One-cycle pulse after a command write |
| cmd_code | output | 8 | Last command byte |

## Verification
The bench builds the block with the default CHIP_ID of 0xA2. This default makes the identification read distinguishable from the counter byte 0xAB that the bench feeds on xfer_count. With that separation, the unlock, the lock and the re-arming on reset can each be observed at offset 14. A vector table covers read-back of the plain registers and the inert offsets. Directed sequences cover the interrupt clear on read and the same-cycle event and command collision.

// File: rtl/scsi_host_regs.sv
module scsi_host_regs #(
  parameter logic [7:0] CHIP_ID = 8'hA2,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [3:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             irq,
  input  logic [CNT_W-1:0] xfer_count,
  input  logic             evt_valid,
  input  logic [7:0]       evt_irq,
  input  logic [3:0]       evt_flags,
  input  logic             phase_we,
  input  logic [2:0]       phase_in,
  output logic [CNT_W-1:0] start_count,
  output logic [7:0]       dest_id,
  output logic             cmd_stb,
  output logic [7:0]       cmd_code
);
  localparam logic [3:0] A_CNT0 = 4'd0, A_CNT1 = 4'd1, A_CMD = 4'd3, A_STAT = 4'd4,
                         A_ISTAT = 4'd5, A_CTL1 = 4'd8, A_CTL2 = 4'd11, A_CTL3 = 4'd12,
                         A_CTL4 = 4'd13, A_CNT2 = 4'd14;
  localparam logic [2:0] PH_STATUS = 3'b011;
  localparam logic [7:0] ISR_DONE = 8'h08;
  localparam logic [7:0] DMA_NOP = 8'h80;

  logic       int_q;
  logic [3:0] flags_q;
  logic [2:0] phase_q;
  logic [7:0] isr_q;
  logic [7:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q;
  logic [7:0] cmd_q, dest_q;
  logic [CNT_W-1:0] start_q;
  logic       id_avail, id_lock, stb_q;

  logic cmd_wr, is_nop, isr_rd, feat_on, top_wr;
  logic [7:0] isr_base, isr_nxt;
  logic int_base;

  assign cmd_wr  = wr_en && addr == A_CMD;
  assign is_nop  = wdata[6:0] == 7'd0;
  assign isr_rd  = rd_en && addr == A_ISTAT;
  assign feat_on = ctl2_q[6];
  assign top_wr  = wr_en && addr == A_CNT2 && feat_on;

  always_comb begin
    isr_base = isr_q;
    int_base = int_q;
    if (cmd_wr) begin
      isr_base = is_nop ? ISR_DONE : 8'h00;
      int_base = is_nop;
    end else if (isr_rd) begin
      int_base = 1'b0;
    end
    isr_nxt = isr_base | (evt_valid ? evt_irq : 8'h00);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      int_q    <= 1'b0;
      flags_q  <= '0;
      phase_q  <= PH_STATUS;
      isr_q    <= '0;
      ctl1_q   <= '0;
      ctl2_q   <= '0;
      ctl3_q   <= '0;
      ctl4_q   <= '0;
      cmd_q    <= '0;
      dest_q   <= '0;
      start_q  <= '0;
      id_avail <= 1'b0;
      id_lock  <= 1'b0;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= cmd_wr;
      isr_q <= isr_nxt;
      int_q <= int_base | evt_valid;
      if (evt_valid) flags_q <= evt_flags;
      if (phase_we) phase_q <= phase_in;
      if (wr_en) begin
        case (addr)
          A_CNT0: start_q[7:0]  <= wdata;
          A_CNT1: start_q[15:8] <= wdata;
          A_CMD: begin
            cmd_q <= wdata;
            if (wdata == DMA_NOP && !id_lock) id_avail <= 1'b1;
          end
          A_STAT: dest_q <= wdata;
          A_CTL1: ctl1_q <= wdata;
          A_CTL2: ctl2_q <= wdata;
          A_CTL3: ctl3_q <= wdata;
          A_CTL4: ctl4_q <= wdata;
          default: ;
        endcase
      end
      if (top_wr) begin
        start_q[CNT_W-1:16] <= wdata[CNT_W-17:0];
        id_avail <= 1'b0;
        id_lock  <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CNT0:  rdata = xfer_count[7:0];
      A_CNT1:  rdata = xfer_count[15:8];
      A_CMD:   rdata = cmd_q;
      A_STAT:  rdata = {int_q, flags_q, phase_q};
      A_ISTAT: rdata = isr_q;
      A_CTL1:  rdata = ctl1_q;
      A_CTL2:  rdata = ctl2_q;
      A_CTL3:  rdata = ctl3_q;
      A_CTL4:  rdata = ctl4_q;
      A_CNT2:  rdata = !feat_on ? 8'h00 : (id_avail ? CHIP_ID : xfer_count[23:16]);
      default: rdata = 8'h00;
    endcase
  end

  assign irq         = int_q;
  assign start_count = start_q;
  assign dest_id     = dest_q;
  assign cmd_stb     = stb_q;
  assign cmd_code    = cmd_q;

  // R4
  evt_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> irq);
  // R5
  isr_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ISTAT && !evt_valid) |=> (!irq && $stable(isr_q)));
  // R6
  cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMD && wdata[6:0] != 7'd0 && !evt_valid) |=> (!irq && isr_q == 8'h00 && cmd_stb));
  // R7
  nop_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CMD && wdata[6:0] == 7'd0 && !evt_valid) |=> (irq && isr_q == ISR_DONE));
  // R10
  lock_hides_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_lock |-> !id_avail);
  // R8
  gate_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_CNT2 && !ctl2_q[6]) |-> rdata == 8'h00);
endmodule

// File: tb/scsi_host_regs_tb_top.sv
module scsi_host_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic irq;
  logic [23:0] xfer_count = 24'hABCDEF;
  logic evt_valid = 1'b0;
  logic [7:0] evt_irq = '0;
  logic [3:0] evt_flags = '0;
  logic phase_we = 1'b0;
  logic [2:0] phase_in = '0;
  logic [23:0] start_count;
  logic [7:0] dest_id;
  logic cmd_stb;
  logic [7:0] cmd_code;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  scsi_host_regs dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .xfer_count(xfer_count),
    .evt_valid(evt_valid), .evt_irq(evt_irq), .evt_flags(evt_flags),
    .phase_we(phase_we), .phase_in(phase_in), .start_count(start_count),
    .dest_id(dest_id), .cmd_stb(cmd_stb), .cmd_code(cmd_code));

  // write addr(4) data(8), read addr(4) expected(8), requirement(8)
  localparam logic [31:0] TBL [10] = '{
    {4'd8,  8'h5A, 4'd8,  8'h5A, 8'd3},
    {4'd11, 8'h3C, 4'd11, 8'h3C, 8'd3},
    {4'd12, 8'hC3, 4'd12, 8'hC3, 8'd3},
    {4'd13, 8'h81, 4'd13, 8'h81, 8'd3},
    {4'd3,  8'h27, 4'd3,  8'h27, 8'd3},
    {4'd9,  8'hFF, 4'd9,  8'h00, 8'd11},
    {4'd15, 8'hFF, 4'd15, 8'h00, 8'd11},
    {4'd2,  8'hFF, 4'd2,  8'h00, 8'd11},
    {4'd6,  8'hEE, 4'd6,  8'h00, 8'd11},
    {4'd5,  8'hFF, 4'd5,  8'h00, 8'd11}
  };

  task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic evt(input logic [7:0] i, input logic [3:0] f);
    @(negedge clk);
    evt_valid = 1'b1; evt_irq = i; evt_flags = f;
    @(negedge clk);
    evt_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    do_reset();
    // R1 reset state
    rd(4'd4, v);  chk("R1 status", v, 8'h03);
    rd(4'd5, v);  chk("R1 isr", v, 8'h00);
    rd(4'd8, v);  chk("R1 ctl1", v, 8'h00);
    rd(4'd11, v); chk("R1 ctl2", v, 8'h00);
    rd(4'd14, v); chk("R1 top", v, 8'h00);
    chk("R1 irq", irq, 1'b0);
    chk("R1 start", start_count, 24'h0);

    // R2
    wr(4'd0, 8'h34); wr(4'd1, 8'h12);
    chk("R2 start", start_count, 24'h001234);
    rd(4'd0, v); chk("R2 cnt lo", v, 8'hEF);
    rd(4'd1, v); chk("R2 cnt mid", v, 8'hCD);

    // R3 / R11 table
    for (int i = 0; i < 10; i++) begin
      wr(TBL[i][31:28], TBL[i][27:20]);
      rd(TBL[i][19:16], v);
      chk($sformatf("R%0d table %0d", TBL[i][7:0], i), v, TBL[i][15:8]);
    end
    wr(4'd4, 8'h05); chk("R3 dest", dest_id, 8'h05);
    rd(4'd4, v); chk("R11 status after write", v, 8'h03);

    // R4 / R5
    @(negedge clk); phase_we = 1'b1; phase_in = 3'b000;
    @(negedge clk); phase_we = 1'b0;
    evt(8'h18, 4'b1001);
    chk("R4 irq", irq, 1'b1);
    rd(4'd4, v); chk("R4 status", v, 8'hC8);
    rd(4'd5, v); chk("R5 isr", v, 8'h18);
    chk("R5 irq drop", irq, 1'b0);
    rd(4'd4, v); chk("R5 status", v, 8'h48);
    rd(4'd5, v); chk("R5 isr kept", v, 8'h18);

    // R6
    evt(8'h40, 4'b0000);
    wr(4'd3, 8'h11);
    chk("R6 stb", cmd_stb, 1'b1);
    chk("R6 code", cmd_code, 8'h11);
    chk("R6 irq", irq, 1'b0);
    @(negedge clk); chk("R6 stb pulse", cmd_stb, 1'b0);
    rd(4'd5, v); chk("R6 isr", v, 8'h00);

    // R7
    evt(8'h40, 4'b0000);
    wr(4'd3, 8'h00);
    chk("R7 irq", irq, 1'b1);
    rd(4'd5, v); chk("R7 isr", v, 8'h08);

    // R12
    @(negedge clk);
    wr_en = 1'b1; addr = 4'd3; wdata = 8'h11;
    evt_valid = 1'b1; evt_irq = 8'h10; evt_flags = 4'b0000;
    @(negedge clk);
    wr_en = 1'b0; evt_valid = 1'b0;
    chk("R12 irq", irq, 1'b1);
    rd(4'd5, v); chk("R12 isr", v, 8'h10);

    // R8 then R9
    wr(4'd11, 8'h00);
    wr(4'd14, 8'h77);
    chk("R8 start top", start_count[23:16], 8'h00);
    rd(4'd14, v); chk("R8 read gated", v, 8'h00);
    wr(4'd3, 8'h80);
    wr(4'd11, 8'h40);
    rd(4'd14, v); chk("R9 chip id", v, 8'hA2);

    // R10
    wr(4'd14, 8'h5C);
    chk("R10 start top", start_count[23:16], 8'h5C);
    rd(4'd14, v); chk("R10 hidden", v, 8'hAB);
    wr(4'd3, 8'h80);
    rd(4'd14, v); chk("R10 locked", v, 8'hAB);
    do_reset();
    rd(4'd11, v); chk("R1 ctl2 after reset", v, 8'h00);
    wr(4'd11, 8'h40);
    wr(4'd3, 8'h00);
    rd(4'd14, v); chk("R9 plain nop", v, 8'hAB);
    wr(4'd3, 8'h80);
    rd(4'd14, v); chk("R10 reset unlocks", v, 8'hA2);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule